// File: doc/BRIEF.md
# Pipelined converter output back-end

This block is the digital tail of a pipelined 10-bit sampling converter. It sits between the raw conversion results and the parallel output pins. Each raw code and its over-range flag enter a fixed-length delay line that runs on the sample clock. The sample clock is either the input clock itself or that clock divided by two. At the far end of the delay line the code is presented as straight binary or as two's complement, and a forwarded output clock marks the word.

Reset is active low. Both the asynchronous power-on reset and the synchronous recalibrate input start a calibration phase. While the recalibrate input is low, the forwarded clock is parked low. Through the whole calibration the over-range output reads high and the data bus reads zero. Calibration is modelled as a busy interval counted in sample clocks, and its length is a parameter. When calibration ends, the delay line is empty and refills before any word is shown.

Top module: `adc_backend`

## Requirements
- R1: A word captured at a sample-clock edge appears on `data_o` just after the 28th sample edge, counting the capture edge as the first. Its over-range flag appears on `ovr_o` in the same cycle.
- R2: A low `recal_ni` sampled at a clock edge places the block in a hold state. The first edge that samples it high starts calibration, which lasts `CAL_LEN` sample edges. With the undivided clock, `ovr_o` falls just after the (`CAL_LEN`+1)th edge following the release.
- R3: `ovr_o` reads 1 from the moment `recal_ni` goes low, with no clock edge needed, and stays 1 through calibration. After that it shows the flag carried with each valid word, and 0 while no valid word has arrived.
- R4: `clk_o` is 0 while `recal_ni` is low. It toggles again from the first rising input edge after `recal_ni` returns high.
- R5: With `fmt_n_i` low, `data_o` is the offset-binary code with bit 9 (the MSB) inverted. With `fmt_n_i` high, the code passes unchanged. Changing `fmt_n_i` alters the output at once and leaves the words in the delay line untouched.
- R6: With `div_n_i` low, the sample clock advances on every second input edge. `clk_o` is then high for one input period and low for the next. A word driven just before a sample edge appears after 55 input edges.
- R7: Releasing `rst_ni` starts a calibration on its own, with no pulse on `recal_ni`. With the undivided clock, `ovr_o` falls just after the `CAL_LEN`th edge.
- R8: `data_o` reads zero during calibration. The first valid word appears 28 sample edges after calibration ends, and `data_o` stays zero until then.
- R9: While `rst_ni` is low, `data_o` is 0, `ovr_o` is 1 and `clk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| recal_ni | input | 1 | Recalibrate request, active low, sampled on clk_i |
| div_n_i | input | 1 | Low: sample clock is clk_i divided by two |
| fmt_n_i | input | 1 | Low: two's-complement output, high: offset binary |
| code_i | input | 10 | Raw conversion code, offset binary |
| ovr_i | input | 1 | Raw over-range flag for code_i |
| data_o | output | 10 | Delayed, formatted output word |
| ovr_o | output | 1 | Over-range flag, also high during calibration |
| clk_o | output | 1 | Forwarded output clock |

## Verification
A stuck or miscounted calibration timer shows up at `ovr_o`. Its falling edge moves away from the expected edge after release, and every later word is shifted by the same amount. A delay line that is one stage off, or a flag that travels apart from its word, shows on the very first ramp word checked 28 edges after capture. A failure to flush the valid bits shows as a non-zero `data_o` during the 27 edges after calibration. A divider phase error moves the word by one input edge, which is visible against the expected 55-edge latency.

// File: rtl/adc_be_pkg.sv
package adc_be_pkg;
  typedef enum logic [1:0] {
    CAL_HOLD = 2'd0,
    CAL_BUSY = 2'd1,
    CAL_RUN  = 2'd2
  } cal_state_e;

  function automatic logic [9:0] fmt_word(input logic [9:0] code, input logic fmt_n);
    return fmt_n ? code : {~code[9], code[8:0]};
  endfunction
endpackage

// File: rtl/adc_be_clkgen.sv
module adc_be_clkgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_n_i,
  input  logic recal_ni,
  output logic smp_en_o,
  output logic clk_o
);
  logic div_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= recal_ni;
      div_q <= (!div_n_i && recal_ni) ? ~div_q : 1'b0;
    end
  end

  // divided sample edge is the one where div_q rises
  assign smp_en_o = div_n_i | ~div_q;
  assign clk_o    = recal_ni & run_q & (div_n_i ? clk_i : div_q);

  p_clk_park_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recal_ni |=> !clk_o);
  p_div_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_n_i |=> smp_en_o);
endmodule

// File: rtl/adc_be_cal.sv
module adc_be_cal
  import adc_be_pkg::*;
#(
  parameter int unsigned CAL_LEN = 1 << 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recal_ni,
  input  logic smp_en_i,
  output logic run_o
);
  localparam int unsigned CW = (CAL_LEN > 2) ? $clog2(CAL_LEN) : 1;

  cal_state_e      state_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAL_BUSY;
      cnt_q   <= '0;
    end else if (!recal_ni) begin
      state_q <= CAL_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CAL_HOLD: state_q <= CAL_BUSY;
        CAL_BUSY: if (smp_en_i) begin
          if (cnt_q == CW'(CAL_LEN - 1)) begin
            state_q <= CAL_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= CAL_RUN;
      endcase
    end
  end

  assign run_o = (state_q == CAL_RUN);

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < (CW+1)'(CAL_LEN));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recal_ni |=> state_q == CAL_HOLD);
  p_run_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && recal_ni) |=> run_o);
endmodule

// File: rtl/adc_be_pipe.sv
module adc_be_pipe #(
  parameter int unsigned WIDTH = 11,
  parameter int unsigned DEPTH = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             flush_i,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] d_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] stg_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stg_q[0] <= '0;
        else if (en_i) stg_q[0] <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stg_q[g] <= '0;
        else if (en_i) stg_q[g] <= stg_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (flush_i) vld_q <= '0;
    else if (en_i)    vld_q <= {vld_q[DEPTH-2:0], vld_i};
  end

  assign vld_o = vld_q[DEPTH-1];
  assign d_o   = stg_q[DEPTH-1];

  p_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !vld_o);
endmodule

// File: rtl/adc_backend.sv
module adc_backend
  import adc_be_pkg::*;
#(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned LATENCY = 28,
  parameter int unsigned CAL_LEN = 1 << 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              recal_ni,
  input  logic              div_n_i,
  input  logic              fmt_n_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              ovr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ovr_o,
  output logic              clk_o
);
  localparam int unsigned PW = DATA_W + 1;

  logic smp_en, run, vld_out;
  logic [PW-1:0] pipe_out;
  logic active;

  adc_be_clkgen u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_n_i (div_n_i),
    .recal_ni(recal_ni),
    .smp_en_o(smp_en),
    .clk_o   (clk_o)
  );

  adc_be_cal #(.CAL_LEN(CAL_LEN)) u_cal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .recal_ni(recal_ni),
    .smp_en_i(smp_en),
    .run_o   (run)
  );

  adc_be_pipe #(.WIDTH(PW), .DEPTH(LATENCY)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (smp_en),
    .flush_i(~run),
    .vld_i  (1'b1),
    .d_i    ({ovr_i, code_i}),
    .vld_o  (vld_out),
    .d_o    (pipe_out)
  );

  assign active = run & recal_ni & vld_out;

  if (DATA_W == 10) begin : g_fmt10
    assign data_o = active ? fmt_word(pipe_out[DATA_W-1:0], fmt_n_i) : '0;
  end else begin : g_fmtn
    assign data_o = !active ? '0 :
                    fmt_n_i ? pipe_out[DATA_W-1:0] :
                    {~pipe_out[DATA_W-1], pipe_out[DATA_W-2:0]};
  end

  assign ovr_o = ~recal_ni | ~run | (vld_out & pipe_out[DATA_W]);

  p_ovr_cal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> ovr_o);
  p_zero_cal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> data_o == '0);
endmodule

// File: tb/adc_backend_bench.sv
module adc_backend_bench;
  localparam int CAL = 16;
  localparam int LAT = 28;

  logic clk_i = 1'b0;
  logic rst_ni, recal_ni, div_n_i, fmt_n_i, ovr_i;
  logic [9:0] code_i, data_o;
  logic ovr_o, clk_o;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  adc_backend #(.CAL_LEN(CAL)) u_adc_backend (
    .clk_i(clk_i), .rst_ni(rst_ni), .recal_ni(recal_ni), .div_n_i(div_n_i),
    .fmt_n_i(fmt_n_i), .code_i(code_i), .ovr_i(ovr_i),
    .data_o(data_o), .ovr_o(ovr_o), .clk_o(clk_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edge_after();
    @(posedge clk_i); #2;
  endtask

  function automatic logic [9:0] pat(input int i);
    return 10'((i * 37 + 5) & 10'h3ff);
  endfunction

  task automatic t_reset();
    rst_ni = 0; recal_ni = 1; div_n_i = 1; fmt_n_i = 1; code_i = '0; ovr_i = 0;
    #23;
    chk("R9 data", 32'(data_o), 0);
    chk("R9 ovr", 32'(ovr_o), 1);
    #4;
    chk("R9 clk_o", 32'(clk_o), 0);
  endtask

  task automatic t_powerup();
    int fall = -1;
    @(negedge clk_i); rst_ni = 1;
    for (int n = 1; n <= CAL + 3; n++) begin
      edge_after();
      if (n == 1) chk("R4 clk_o after power-up", 32'(clk_o), 1);
      if (fall < 0 && !ovr_o) fall = n;
      if (fall < 0) chk("R8 data zero in power-up cal", 32'(data_o), 0);
    end
    chk("R7 power-up cal length", 32'(fall), 32'(CAL));
  endtask

  task automatic t_latency();
    logic [9:0] c [80];
    logic o [80];
    for (int i = 0; i < 80; i++) begin
      @(negedge clk_i);
      c[i] = pat(i); o[i] = (i % 5 == 0);
      code_i = c[i]; ovr_i = o[i];
      edge_after();
      if (i >= LAT - 1) begin
        chk("R1 data latency", 32'(data_o), 32'(c[i-LAT+1]));
        chk("R1 ovr aligned", 32'(ovr_o), 32'(o[i-LAT+1]));
      end
    end
  endtask

  task automatic t_format();
    @(negedge clk_i); code_i = 10'h2a5; ovr_i = 0;
    repeat (LAT + 1) edge_after();
    chk("R5 binary", 32'(data_o), 32'h2a5);
    @(negedge clk_i); fmt_n_i = 0; #1;
    chk("R5 twos immediate", 32'(data_o), 32'h0a5);
    repeat (3) edge_after();
    chk("R5 twos held", 32'(data_o), 32'h0a5);
    @(negedge clk_i); code_i = 10'h05a;
    repeat (LAT) edge_after();
    chk("R5 twos low code", 32'(data_o), 32'h25a);
    @(negedge clk_i); fmt_n_i = 1; #1;
    chk("R5 pipeline untouched", 32'(data_o), 32'h05a);
  endtask

  task automatic t_recal();
    int fall = -1, first = -1;
    @(negedge clk_i); code_i = 10'h155; ovr_i = 0; recal_ni = 0; #1;
    chk("R3 ovr immediate", 32'(ovr_o), 1);
    chk("R8 data zero on recal", 32'(data_o), 0);
    for (int k = 0; k < 3; k++) begin
      edge_after();
      chk("R4 clk_o parked", 32'(clk_o), 0);
      chk("R3 ovr in hold", 32'(ovr_o), 1);
    end
    @(negedge clk_i); recal_ni = 1;
    for (int n = 1; n <= CAL + 4; n++) begin
      edge_after();
      if (n == 1) chk("R4 clk_o resumes", 32'(clk_o), 1);
      if (fall < 0 && !ovr_o) fall = n;
    end
    chk("R2 recal length", 32'(fall), 32'(CAL + 1));
    // fall + 3 edges already elapsed
    for (int m = 4; m <= LAT + 2; m++) begin
      edge_after();
      if (first < 0 && data_o != 0) first = m;
    end
    chk("R8 first valid edge", 32'(first), 32'(LAT));
    chk("R8 first valid word", 32'(data_o), 32'h155);
  endtask

  task automatic t_divided();
    logic v;
    int chg = -1;
    @(negedge clk_i); div_n_i = 0;
    for (int k = 0; k < 8; k++) begin
      edge_after();
      v = clk_o;
      chk("R6 clk_o high phase", 32'(v), 32'(k % 2 == 0));
      @(negedge clk_i); #2;
      chk("R6 clk_o duty", 32'(clk_o), 32'(v));
    end
    code_i = 10'h2cc; ovr_i = 1;
    for (int n = 1; n <= 56; n++) begin
      edge_after();
      if (chg < 0 && data_o == 10'h2cc) chg = n;
      if (n == 54) chk("R6 old word held", 32'(data_o), 32'h155);
    end
    chk("R6 divided latency", 32'(chg), 55);
    chk("R6 ovr follows word", 32'(ovr_o), 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_powerup();
    t_latency();
    t_format();
    t_recal();
    t_divided();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule